// File: doc/BRIEF.md
# Paired-Channel Programmable Phase Aligner

This block sits behind six sampled data channels that are grouped into three pairs: channels 0 and 1, channels 2 and 3, and channels 4 and 5. Within each pair the odd channel is the timing reference. A signed 8-bit code per pair sets both how far and in which direction the even channel is shifted against the odd one. The unit of shift is one clock tick.

A positive code delays the even channel by the code value. A negative code delays the odd channel by the magnitude, so the even channel leads. A zero code shifts neither channel. The three codes live in one 24-bit register that can be written and read back. Every output is registered, so an undelayed channel appears one cycle after its input.

A write to the register takes effect on the next clock edge and discards whatever the delay lines hold. The strobes of a delayed channel stay low until the line has refilled to the new depth. Each pair keeps one circular buffer, used by whichever channel the sign selects, and a fill counter that gates the buffer's output.

Top module: `pair_phase_aligner`

## Requirements
- R1: While reset is asserted and after its release, the configuration readback is 0 and every output strobe is low until an input strobe arrives.
- R2: A write stores the 24-bit word, and the readback port returns that word from the next cycle on.
- R3: The register field at bits 7:0 controls the pair of channels 0/1, bits 15:8 controls channels 2/3 and bits 23:16 controls channels 4/5. A pair's output timing depends only on its own field.
- R4: For a field value N with bit 7 clear and N non-zero, the odd channel's strobe and word appear 1 cycle after input, and the even channel's appear 1+N cycles after input.
- R5: For a field with bit 7 set, taken as an 8-bit two's-complement value −M, the even channel appears 1 cycle after input and the odd channel 1+M cycles after input. The code 0x80 gives M = 128.
- R6: A field value of zero gives both channels of the pair a latency of 1 cycle.
- R7: After any register write, the delayed channel of each pair outputs no strobe for exactly M cycles, where M is the new delay magnitude. Input strobes are continuous during this time. The reference channel's strobes continue without a gap.
- R8: An output data word is zero in every cycle where its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per delay step |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 6 | Per-channel input sample strobe, bit c for channel c |
| smp_data_i | input | 96 | Per-channel sample words, channel c in bits 16c+15:16c |
| cfg_we_i | input | 1 | Register write enable |
| cfg_wdata_i | input | 24 | Register write data |
| cfg_rdata_o | output | 24 | Register readback |
| aln_vld_o | output | 6 | Realigned sample strobes, bit c for channel c |
| aln_data_o | output | 96 | Realigned sample words, same layout as the input |

## Verification
The bench builds the block with its default parameters: three pairs, 16-bit words and 8-bit codes, which gives buffers 128 entries deep. These values put the extreme codes +127 and −128 within reach, so the full buffer depth and the wrap of the read pointer onto the write slot are exercised. The sample words carry a 12-bit ramp, so the offset between the two channels of a pair can be read straight from the data. Single-strobe pulses check the exact latency, including 129 cycles for −128.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
    parameter int unsigned PAIR_CNT = 3;
    parameter int unsigned SMP_W    = 16;
    parameter int unsigned PH_W     = 8;
endpackage

// File: rtl/ppa_code_decode.sv
module ppa_code_decode #(
    parameter int unsigned CODE_W = ppa_pkg::PH_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              dly_odd_o,
    output logic [CODE_W-1:0] mag_o
);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    // sign bit picks the delayed member; magnitude fits CODE_W bits unsigned
    always_comb begin
        dly_odd_o = code_i[CODE_W-1];
        mag_o     = dly_odd_o ? (~code_i + ONE) : code_i;
    end
endmodule

// File: rtl/ppa_pair_delay.sv
module ppa_pair_delay #(
    parameter int unsigned DATA_W = ppa_pkg::SMP_W,
    parameter int unsigned CODE_W = ppa_pkg::PH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic [CODE_W-1:0]   code_i,
    input  logic [1:0]          vld_i,
    input  logic [2*DATA_W-1:0] data_i,
    output logic [1:0]          vld_o,
    output logic [2*DATA_W-1:0] data_o
);
    localparam int unsigned AW     = CODE_W - 1;
    localparam int unsigned DEPTH  = 1 << AW;
    localparam int unsigned WORD_W = DATA_W + 1;
    localparam logic [AW-1:0]     WP_ONE   = AW'(1);
    localparam logic [CODE_W-1:0] FILL_ONE = CODE_W'(1);
    localparam logic [CODE_W-1:0] FILL_MAX = CODE_W'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]         wp;
        logic [CODE_W-1:0]     fill;
        logic [1:0]            vld;
        logic [2*DATA_W-1:0]   data;
    } pair_st_t;

    pair_st_t st_d, st_q;

    logic              dly_odd;
    logic [CODE_W-1:0] mag;

    ppa_code_decode #(.CODE_W(CODE_W)) u_dec (
        .code_i    (code_i),
        .dly_odd_o (dly_odd),
        .mag_o     (mag)
    );

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] wr_word, rd_word, dly_word, ref_word;
    logic [DATA_W-1:0] d_even, d_odd, dly_dat, ref_dat;
    logic              dly_v, ref_v;

    assign d_even = data_i[DATA_W-1:0];
    assign d_odd  = data_i[2*DATA_W-1:DATA_W];

    always_comb begin
        st_d     = st_q;
        wr_word  = dly_odd ? {vld_i[1], d_odd}  : {vld_i[0], d_even};
        ref_word = dly_odd ? {vld_i[0], d_even} : {vld_i[1], d_odd};
        // entry written mag cycles ago; mag of DEPTH wraps onto the slot being overwritten
        rd_word  = mem_q[st_q.wp - mag[AW-1:0]];
        dly_word = (mag == '0) ? wr_word : rd_word;
        dly_v    = dly_word[DATA_W] && (st_q.fill >= mag);
        ref_v    = ref_word[DATA_W];
        dly_dat  = dly_v ? dly_word[DATA_W-1:0] : '0;
        ref_dat  = ref_v ? ref_word[DATA_W-1:0] : '0;

        st_d.wp = st_q.wp + WP_ONE;
        if (flush_i)
            st_d.fill = '0;
        else if (st_q.fill < FILL_MAX)
            st_d.fill = st_q.fill + FILL_ONE;

        if (dly_odd) begin
            st_d.vld  = {dly_v, ref_v};
            st_d.data = {dly_dat, ref_dat};
        end else begin
            st_d.vld  = {ref_v, dly_v};
            st_d.data = {ref_dat, dly_dat};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        mem_q[st_q.wp] <= wr_word;
    end

    assign vld_o  = st_q.vld;
    assign data_o = st_q.data;

    // R6
    zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mag == '0) |=> (vld_o == $past(vld_i)));
    // R4
    ref_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_odd |=> (vld_o[1] == $past(vld_i[1])));
    // R5
    ref_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_odd |=> (vld_o[0] == $past(vld_i[0])));
    // R7
    fill_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dly_odd && (st_q.fill < mag)) |=> !vld_o[0]);
    // R7
    fill_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_odd && (st_q.fill < mag)) |=> !vld_o[1]);
    // R8
    zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o[0] |-> (data_o[DATA_W-1:0] == '0));
endmodule

// File: rtl/pair_phase_aligner.sv
module pair_phase_aligner #(
    parameter int unsigned NUM_PAIRS = ppa_pkg::PAIR_CNT,
    parameter int unsigned DATA_W    = ppa_pkg::SMP_W,
    parameter int unsigned CODE_W    = ppa_pkg::PH_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [2*NUM_PAIRS-1:0]              smp_vld_i,
    input  logic [2*NUM_PAIRS*DATA_W-1:0]       smp_data_i,
    input  logic                                cfg_we_i,
    input  logic [NUM_PAIRS*CODE_W-1:0]         cfg_wdata_i,
    output logic [NUM_PAIRS*CODE_W-1:0]         cfg_rdata_o,
    output logic [2*NUM_PAIRS-1:0]              aln_vld_o,
    output logic [2*NUM_PAIRS*DATA_W-1:0]       aln_data_o
);
    localparam int unsigned CFG_W = NUM_PAIRS * CODE_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) st_d.cfg = cfg_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata_o = st_q.cfg;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        ppa_pair_delay #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (cfg_we_i),
            .code_i  (st_q.cfg[p*CODE_W +: CODE_W]),
            .vld_i   (smp_vld_i[2*p +: 2]),
            .data_i  (smp_data_i[2*p*DATA_W +: 2*DATA_W]),
            .vld_o   (aln_vld_o[2*p +: 2]),
            .data_o  (aln_data_o[2*p*DATA_W +: 2*DATA_W])
        );
    end

    // R2
    cfg_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_rdata_o == $past(cfg_wdata_i)));
endmodule

// File: tb/tb_pair_phase_aligner.sv
`timescale 1ns/1ps
module tb_pair_phase_aligner;
    localparam int NP  = 3;
    localparam int DW  = 16;
    localparam int CW  = 8;
    localparam int NCH = 2*NP;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    vld_mask = '0;
    logic [NCH*DW-1:0] din = '0;
    logic              cfg_we = 1'b0;
    logic [NP*CW-1:0]  cfg_wd = '0;
    logic [NP*CW-1:0]  cfg_rd;
    logic [NCH-1:0]    aln_vld;
    logic [NCH*DW-1:0] aln_data;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [11:0] ramp = '0;

    always #2 clk = ~clk;

    pair_phase_aligner dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld_i   (vld_mask),
        .smp_data_i  (din),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (cfg_wd),
        .cfg_rdata_o (cfg_rd),
        .aln_vld_o   (aln_vld),
        .aln_data_o  (aln_data)
    );

    // ramp stimulus: channel c carries {c, ramp}
    initial begin
        forever begin
            @(negedge clk);
            ramp = ramp + 12'd1;
            for (int c = 0; c < NCH; c++) din[c*DW +: DW] = {4'(c), ramp};
        end
    end

    task automatic chk_eq(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [NP*CW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wd = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_offset(input int p, input logic [7:0] code, input string tag);
        logic [DW-1:0] e, o;
        logic [11:0]   d;
        @(negedge clk);
        e = aln_data[2*p*DW +: DW];
        o = aln_data[(2*p+1)*DW +: DW];
        d = o[11:0] - e[11:0];
        chk_eq({tag, " strobes"}, int'(aln_vld[2*p +: 2]), 3);
        chk_eq({tag, " even tag"}, int'(e[15:12]), 2*p);
        chk_eq({tag, " offset"}, int'($signed(d)), int'($signed(code)));
    endtask

    task automatic measure_lat(input int ch, input int exp, input string tag);
        int lat = 0;
        @(negedge clk);
        vld_mask = NCH'(1) << ch;
        for (int i = 1; i <= 160; i++) begin
            @(negedge clk);
            if (i == 1) vld_mask = '0;
            if (lat == 0 && aln_vld[ch]) lat = i;
        end
        chk_eq(tag, lat, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_cyc(5);
        chk_eq("R1 readback in reset", int'(cfg_rd), 0);
        chk_eq("R1 strobes in reset", int'(aln_vld), 0);
        rst_n = 1'b1;
        wait_cyc(3);
        chk_eq("R1 readback after reset", int'(cfg_rd), 0);
        chk_eq("R1 strobes idle after reset", int'(aln_vld), 0);
    endtask

    task automatic t_zero();
        vld_mask = '1;
        wait_cyc(10);
        for (int p = 0; p < NP; p++) check_offset(p, 8'h00, "R6 zero code");
    endtask

    task automatic t_map();
        write_cfg(24'h807F00);
        chk_eq("R2 readback", int'(cfg_rd), int'(24'h807F00));
        wait_cyc(140);
        check_offset(0, 8'h00, "R3 R6 pair0 zero");
        check_offset(1, 8'h7F, "R3 R4 pair1 +127");
        check_offset(2, 8'h80, "R3 R5 pair2 -128");
    endtask

    task automatic t_flush();
        int z0 = 0;
        int z1 = 0;
        int dz = 0;
        write_cfg(24'h807F05);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!aln_vld[0]) begin
                z0++;
                if (aln_data[DW-1:0] != '0) dz++;
            end
            if (!aln_vld[1]) z1++;
        end
        chk_eq("R7 suppressed even strobes", z0, 5);
        chk_eq("R7 reference strobe gaps", z1, 0);
        chk_eq("R8 nonzero data without strobe", dz, 0);
        wait_cyc(140);
        check_offset(0, 8'h05, "R3 pair0 +5");
        check_offset(1, 8'h7F, "R3 pair1 untouched");
        check_offset(2, 8'h80, "R3 pair2 untouched");
    endtask

    task automatic t_lat();
        vld_mask = '0;
        write_cfg(24'h00FE03);
        wait_cyc(140);
        measure_lat(0, 4, "R4 ch0 latency +3");
        measure_lat(1, 1, "R4 ch1 reference latency");
        measure_lat(2, 1, "R5 ch2 leading latency");
        measure_lat(3, 3, "R5 ch3 latency -2");
        measure_lat(4, 1, "R6 ch4 latency");
        measure_lat(5, 1, "R6 ch5 latency");
    endtask

    task automatic t_lat_max();
        vld_mask = '0;
        write_cfg(24'h800000);
        wait_cyc(140);
        measure_lat(5, 129, "R5 ch5 latency -128");
        measure_lat(4, 1, "R5 ch4 latency at -128");
    endtask

    task automatic t_mix();
        vld_mask = '1;
        write_cfg(24'h40FF01);
        wait_cyc(140);
        check_offset(0, 8'h01, "R4 pair0 +1");
        check_offset(1, 8'hFF, "R5 pair1 -1");
        check_offset(2, 8'h40, "R4 pair2 +64");
    endtask

    initial begin
        t_reset();
        t_zero();
        t_map();
        t_flush();
        t_lat();
        t_lat_max();
        t_mix();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule